// File: doc/BRIEF.md
# Cluster CPU Power State Controller

This block sequences power for a cluster of up to four CPU cores. Software talks to it through a small 32-bit register port. Setting a bit in the wake register powers up that core. Writing the arm code into a core's control register prepares that core for standby. An armed core powers down only when it next signals wait-for-interrupt, so software can arm standby first and let the core idle into it.

Each core has its own sequencer. A power-up keeps the core's power enable high and holds its reset for a fixed number of cycles, then releases reset. A power-down drops both outputs together. The state of every core can be read from one packed status word. A separate read-write register holds the debug reset-enable bits.

The register port accepts a request in every cycle: `req_ready` is always high and there is no back-pressure. Read data comes back on `rsp_valid`/`rsp_rdata` one cycle after the read is accepted. Writes return no response.

Top module: `cluster_pwr_ctl`

## Requirements
- R1: After reset, core 0 runs and every other core is in standby (`core_pwr_en` = `core_rst_n` = 4'b0001). The status register at 0x40 reads 0x00003330. The wake register (0x10), the four control registers (0x100 + 0x10*n) and the debug register (0x180) all read 0.
- R2: `req_ready` is always 1. An accepted read returns `rsp_valid` = 1 with its data exactly one cycle later. A read of an unmapped offset returns 0.
- R3: Writing 1 to bit n of 0x10 when core n is in standby starts power-up one cycle after the write. During power-up `core_pwr_en[n]` is 1, `core_rst_n[n]` is 0 and the 2-bit status field at bits 4n+1:4n reads 1. Reset is never released while power is off.
- R4: Reset is held for PWRUP_CYCLES (16) cycles. `core_rst_n[n]` rises 1+PWRUP_CYCLES cycles after the wake write is accepted. The status field then reads 0 (run). Wake bit n reads 1 until that moment and 0 afterwards.
- R5: A wake bit written for a core that is already running clears by itself within two cycles, and the power outputs do not change.
- R6: Writing 3 to a core's control register arms standby and reads back as 3. Arming alone changes no output.
- R7: An armed running core that asserts `core_wfi` drops `core_pwr_en` and `core_rst_n` one cycle later. Its status reads 2 for one cycle and then 3. The control register clears to 0.
- R8: `core_wfi` from a core that is not armed has no effect.
- R9: A wake request that arrives while a core is powering down is held. Power-up starts once the core reaches standby.
- R10: If a wake is pending for a running core in the same cycle as an armed `core_wfi`, the power-down goes ahead. The wake bit stays set, and the core is then powered back up.
- R11: In the debug register (0x180) only bits 24, 19 and 20+n (for each core n) can be written. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| core_wfi | input | 4 | Per-core wait-for-interrupt |
| core_pwr_en | output | 4 | Per-core power enable |
| core_rst_n | output | 4 | Per-core reset release (1 = running) |

## Verification
The wake-clear path and the standby entry can fire on the same edge when a core has a pending wake and executes an armed WFI. The bench provokes this by writing the wake bit one cycle before pulsing `core_wfi`. Power-down must win: the power outputs fall one cycle later while the wake bit still reads 1, and the core is then seen to come back to run. A second case places the wake write inside the one-cycle power-down window, and the wake must be held until standby is reached.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_WAKING   = 2'd1,
    ST_SLEEPING = 2'd2,
    ST_STANDBY  = 2'd3
  } core_st_e;

  localparam logic [11:0] OFS_WAKE   = 12'h010;
  localparam logic [11:0] OFS_STATUS = 12'h040;
  localparam logic [11:0] OFS_CTL0   = 12'h100;
  localparam logic [11:0] OFS_DBG    = 12'h180;
  localparam logic [1:0]  ARM_CODE   = 2'd3;
endpackage

// File: rtl/cpc_core_seq.sv
module cpc_core_seq
  import cpc_pkg::*;
#(
  parameter int PWRUP_CYCLES = 16,
  parameter bit BOOT_RUN     = 1'b0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wake_pend,
  input  logic     armed,
  input  logic     wfi,
  output core_st_e state,
  output logic     pwr_en,
  output logic     rel_rst,
  output logic     wake_done,
  output logic     arm_clr
);
  localparam int CW = $clog2(PWRUP_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(PWRUP_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          go_down;

  assign go_down   = (state == ST_RUN) && armed && wfi;
  assign arm_clr   = go_down;
  assign wake_done = ((state == ST_RUN) && wake_pend && !go_down) ||
                     ((state == ST_WAKING) && (cnt_q == LAST));
  assign pwr_en    = (state == ST_RUN) || (state == ST_WAKING);
  assign rel_rst   = (state == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= BOOT_RUN ? ST_RUN : ST_STANDBY;
      cnt_q <= '0;
    end else begin
      unique case (state)
        ST_RUN:      if (go_down) state <= ST_SLEEPING;
        ST_SLEEPING: state <= ST_STANDBY;
        ST_STANDBY:  if (wake_pend) begin
                       state <= ST_WAKING;
                       cnt_q <= '0;
                     end
        ST_WAKING:   if (cnt_q == LAST) state <= ST_RUN;
                     else cnt_q <= cnt_q + 1'b1;
        default:     state <= ST_STANDBY;
      endcase
    end
  end
endmodule

// File: rtl/cpc_regfile.sv
module cpc_regfile
  import cpc_pkg::*;
#(
  parameter int NCORES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [11:0]         req_addr,
  input  logic [31:0]         req_wdata,
  output logic                rsp_valid,
  output logic [31:0]         rsp_rdata,
  input  logic [2*NCORES-1:0] core_states,
  input  logic [NCORES-1:0]   wake_done,
  input  logic [NCORES-1:0]   arm_clr,
  output logic [NCORES-1:0]   wake_pend,
  output logic [NCORES-1:0]   armed
);
  localparam logic [31:0] DBG_MASK = 32'h0108_0000 | (((32'h1 << NCORES) - 32'h1) << 20);

  logic [NCORES-1:0]  wake_q;
  logic [1:0]         ctl_q [NCORES];
  logic [31:0]        dbg_q;
  logic [NCORES-1:0]  ctl_hit;
  logic [31:0]        status_w;
  logic [31:0]        rd_mux;
  logic               wr;

  assign wr        = req_valid && req_write;
  assign wake_pend = wake_q;

  always_comb begin
    status_w = '0;
    for (int n = 0; n < NCORES; n++) status_w[4*n +: 2] = core_states[2*n +: 2];
  end

  for (genvar n = 0; n < NCORES; n++) begin : g_ctl
    assign ctl_hit[n] = (req_addr == OFS_CTL0 + 12'(16 * n));
    assign armed[n]   = (ctl_q[n] == ARM_CODE);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  ctl_q[n] <= '0;
      else if (wr && ctl_hit[n])   ctl_q[n] <= req_wdata[1:0];
      else if (arm_clr[n])         ctl_q[n] <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_q <= '0;
      dbg_q  <= '0;
    end else begin
      wake_q <= (wake_q & ~wake_done) |
                ((wr && req_addr == OFS_WAKE) ? req_wdata[NCORES-1:0] : '0);
      if (wr && req_addr == OFS_DBG) dbg_q <= req_wdata & DBG_MASK;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (req_addr == OFS_WAKE)   rd_mux = 32'(wake_q);
    if (req_addr == OFS_STATUS) rd_mux = status_w;
    if (req_addr == OFS_DBG)    rd_mux = dbg_q;
    for (int n = 0; n < NCORES; n++)
      if (ctl_hit[n]) rd_mux = 32'(ctl_q[n]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rsp_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/cluster_pwr_ctl.sv
module cluster_pwr_ctl
  import cpc_pkg::*;
#(
  parameter int NCORES       = 4,
  parameter int PWRUP_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [11:0]       req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic [NCORES-1:0] core_wfi,
  output logic [NCORES-1:0] core_pwr_en,
  output logic [NCORES-1:0] core_rst_n
);
  logic [2*NCORES-1:0] states;
  logic [NCORES-1:0]   wake_done, arm_clr, wake_pend, armed;

  assign req_ready = 1'b1;

  cpc_regfile #(.NCORES(NCORES)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .core_states(states), .wake_done(wake_done), .arm_clr(arm_clr),
    .wake_pend(wake_pend), .armed(armed)
  );

  for (genvar n = 0; n < NCORES; n++) begin : g_core
    core_st_e st;
    cpc_core_seq #(.PWRUP_CYCLES(PWRUP_CYCLES), .BOOT_RUN(n == 0)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .wake_pend(wake_pend[n]), .armed(armed[n]), .wfi(core_wfi[n]),
      .state(st), .pwr_en(core_pwr_en[n]), .rel_rst(core_rst_n[n]),
      .wake_done(wake_done[n]), .arm_clr(arm_clr[n])
    );
    assign states[2*n +: 2] = st;
  end
endmodule

// File: rtl/cpc_checker.sv
module cpc_checker #(
  parameter int NCORES       = 4,
  parameter int PWRUP_CYCLES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic              rsp_valid,
  input logic [NCORES-1:0] core_wfi,
  input logic [NCORES-1:0] core_pwr_en,
  input logic [NCORES-1:0] core_rst_n
);
  assert_rsp_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  assert_no_stray_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));
  assert_rst_needs_power_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst_n & ~core_pwr_en) == '0);

  for (genvar n = 0; n < NCORES; n++) begin : g_chk
    logic [15:0] held_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              held_q <= '0;
      else if (!core_pwr_en[n]) held_q <= '0;
      else if (!core_rst_n[n])  held_q <= held_q + 16'd1;
      else                      held_q <= '0;
    end
    assert_reset_hold_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_rst_n[n]) |-> (held_q == 16'(PWRUP_CYCLES)));
    assert_down_only_on_wfi_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_pwr_en[n]) |-> $past(core_wfi[n]));
  end
endmodule

bind cluster_pwr_ctl cpc_checker #(.NCORES(NCORES), .PWRUP_CYCLES(PWRUP_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid), .core_wfi(core_wfi), .core_pwr_en(core_pwr_en),
  .core_rst_n(core_rst_n)
);

// File: tb/cluster_pwr_ctl_test.sv
module cluster_pwr_ctl_test;
  localparam int N  = 4;
  localparam int PU = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic [N-1:0] core_wfi = '0, core_pwr_en, core_rst_n;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  cluster_pwr_ctl #(.NCORES(N), .PWRUP_CYCLES(PU)) uut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: pops one expected item per read response
  always @(negedge clk) if (rst_n && rsp_valid) begin
    if (exp_q.size() == 0) chk(1'b0, "R2", "unexpected response", rsp_rdata, 0);
    else begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(rsp_rdata === e, t, "read data", rsp_rdata, e);
    end
  end

  // tasks are called just after a falling edge
  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic bus_read(input logic [11:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    chk(req_ready === 1'b1, "R2", "ready high", 32'(req_ready), 1);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_run(input int idx, output int n);
    n = 0;
    while (core_rst_n[idx] !== 1'b1 && n < 60) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(core_pwr_en === 4'b0001, "R1", "pwr_en", 32'(core_pwr_en), 1);
    chk(core_rst_n  === 4'b0001, "R1", "rst_n", 32'(core_rst_n), 1);
    bus_read(12'h040, 32'h0000_3330, "R1");
    bus_read(12'h010, 0, "R1");
    for (int c = 0; c < N; c++) bus_read(12'h100 + 12'(16 * c), 0, "R1");
    bus_read(12'h180, 0, "R1");
    bus_read(12'h200, 0, "R2");   // R2 unmapped
    bus_read(12'h044, 0, "R2");
    // R11 debug mask
    bus_write(12'h180, 32'hFFFF_FFFF);
    bus_read(12'h180, 32'h01F8_0000, "R11");
    bus_write(12'h180, 32'h0010_0001);
    bus_read(12'h180, 32'h0010_0000, "R11");

    // R3/R4 wake core 1, timing of reset release
    bus_write(12'h010, 32'h2);
    n = 0;
    while (core_rst_n[1] !== 1'b1 && n < 60) begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        chk(core_pwr_en[1] === 1'b1, "R3", "pwr on", 32'(core_pwr_en), 32'h3);
        chk(core_rst_n[1]  === 1'b0, "R3", "still reset", 32'(core_rst_n), 32'h1);
      end
    end
    chk(n == PU + 1, "R4", "cycles to reset release", n, PU + 1);
    bus_read(12'h010, 0, "R4");
    bus_read(12'h040, 32'h0000_3300, "R4");

    // R3 status and pending wake during power-up of core 2
    bus_write(12'h010, 32'h4);
    @(negedge clk);
    bus_read(12'h010, 32'h4, "R4");
    bus_read(12'h040, 32'h0000_3100, "R3");
    wait_run(2, n);
    chk(core_rst_n === 4'b0111, "R4", "core2 running", 32'(core_rst_n), 32'h7);
    bus_read(12'h010, 0, "R4");

    // R5 wake to a running core
    bus_write(12'h010, 32'h1);
    @(negedge clk);
    bus_read(12'h010, 0, "R5");
    chk(core_pwr_en === 4'b0111 && core_rst_n === 4'b0111, "R5", "no change",
        32'(core_pwr_en), 32'h7);

    // R6 arm core 1, R8 unarmed wfi on core 2
    bus_write(12'h110, 32'h3);
    bus_read(12'h110, 32'h3, "R6");
    chk(core_pwr_en === 4'b0111, "R6", "arming alone", 32'(core_pwr_en), 32'h7);
    core_wfi = 4'b0100;
    @(negedge clk);
    core_wfi = '0;
    @(negedge clk);
    chk(core_pwr_en === 4'b0111, "R8", "unarmed wfi", 32'(core_pwr_en), 32'h7);
    bus_read(12'h040, 32'h0000_3000, "R8");

    // R7 armed wfi on core 1
    core_wfi = 4'b0010;
    @(negedge clk);
    core_wfi = '0;
    chk(core_pwr_en === 4'b0101 && core_rst_n === 4'b0101, "R7", "power down",
        32'(core_pwr_en), 32'h5);
    bus_read(12'h040, 32'h0000_3020, "R7");
    bus_read(12'h040, 32'h0000_3030, "R7");
    bus_read(12'h110, 0, "R7");

    // R9 wake during power-down of core 2
    bus_write(12'h120, 32'h3);
    core_wfi = 4'b0100;
    @(negedge clk);
    core_wfi = '0;
    bus_write(12'h010, 32'h4);
    chk(core_pwr_en[2] === 1'b0, "R9", "down first", 32'(core_pwr_en), 32'h1);
    wait_run(2, n);
    chk(core_rst_n[2] === 1'b1, "R9", "held wake powers up", 32'(core_rst_n), 32'h5);

    // R10 pending wake and armed wfi on the same edge (core 1)
    bus_write(12'h010, 32'h2);
    wait_run(1, n);
    bus_write(12'h110, 32'h3);
    bus_write(12'h010, 32'h2);
    core_wfi = 4'b0010;
    @(negedge clk);
    core_wfi = '0;
    chk(core_pwr_en[1] === 1'b0, "R10", "power-down wins", 32'(core_pwr_en), 32'h5);
    bus_read(12'h010, 32'h2, "R10");
    wait_run(1, n);
    chk(core_rst_n === 4'b0111, "R10", "core back to run", 32'(core_rst_n), 32'h7);
    bus_read(12'h010, 0, "R10");
    bus_read(12'h040, 32'h0000_3000, "R10");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2", "all reads answered", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule